// File: doc/BRIEF.md
# Stop-Clock Power-State Sequencer

This block sits on the processor side of a low-power handshake. System logic lowers an active-low stop request. The block synchronizes that request, filters out glitches and waits for the core to reach an instruction boundary. It then steps through a fixed sequence. First it asks the pipeline to flush, then it waits for the bus unit to go idle, and then it issues one acknowledge special bus cycle. When the ready strobe of that cycle has been seen and the write buffer has drained, the block gates the core clock and reports the stop-grant state.

From stop-grant, system logic may also halt the bus clock. The block follows it into a deeper stop-clock state and comes back out when the bus clock runs again. Raising the request while in stop-grant restores the core clock on the next cycle. If the request is withdrawn before the handshake completes, the sequence still runs to the end, but a sticky error bit records the violation. The real pipeline, bus unit and clock tree sit outside this block.

Top module: `stopclk_seq`

## Requirements
- R1: After reset, `state_onehot` is 8'b0000_0001 (RUN), `core_clk_en` is 1, and `flush_req`, `ack_issue` and `proto_err` are 0.
- R2: `stop_req_n` passes through a two-flop synchronizer and counts only after the synchronized level has been low for at least two consecutive clocks. A single-cycle low pulse leaves the block in RUN, while a low of two or more cycles reaches WAIT_BOUNDARY.
- R3: A qualified request in RUN moves the block to WAIT_BOUNDARY. It stays there until `insn_boundary` is sampled high, and then moves to FLUSH.
- R4: In FLUSH, `flush_req` is held high until `flush_done` is sampled high. The only exit from FLUSH is to DRAIN.
- R5: DRAIN waits for `bus_idle`. The following ACK state drives `ack_issue` high for exactly one cycle, and the next state is WAIT_READY.
- R6: WAIT_READY moves to STOP_GRANT only once both `ack_ready` and `wrbuf_empty` have been sampled high. The two may arrive in the same cycle or in different cycles, in either order. With `wrbuf_ignore` = 1, `wrbuf_empty` has no effect.
- R7: `core_clk_en` is 0 exactly in STOP_GRANT and STOP_CLOCK. It falls only when leaving WAIT_READY.
- R8: In STOP_GRANT, `bus_clk_running` = 0 moves the block to STOP_CLOCK. STOP_CLOCK returns to STOP_GRANT when `bus_clk_running` = 1.
- R9: In STOP_GRANT, a deasserted synchronized request returns the block to RUN on the next clock, even if `bus_clk_running` is low in that same cycle.
- R10: `proto_err` becomes 1 when the synchronized request is high (deasserted) in WAIT_BOUNDARY through WAIT_READY before `ack_ready` has been seen. It stays 1 until reset, and the sequence continues regardless.
- R11: `state_onehot` always has exactly one bit set. The bit order is 0 RUN, 1 WAIT_BOUNDARY, 2 FLUSH, 3 DRAIN, 4 ACK, 5 WAIT_READY, 6 STOP_GRANT, 7 STOP_CLOCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Active-low stop request, may be asynchronous |
| insn_boundary | input | 1 | Strobe: the core is at an instruction boundary |
| flush_req | output | 1 | Request to flush the instruction pipeline |
| flush_done | input | 1 | The pipeline flush has completed |
| bus_idle | input | 1 | No pending or in-progress bus cycle |
| ack_issue | output | 1 | One-cycle command to issue the acknowledge special cycle |
| ack_ready | input | 1 | Ready strobe of the acknowledge cycle |
| wrbuf_empty | input | 1 | The write buffer is empty |
| wrbuf_ignore | input | 1 | 1 = ignore `wrbuf_empty` |
| bus_clk_running | input | 1 | 0 = system logic has stopped the bus clock |
| core_clk_en | output | 1 | Enable for the core clock gate |
| state_onehot | output | 8 | One-hot state, bit order as in R11 |
| proto_err | output | 1 | Sticky: request withdrawn before recognition |

## Verification
The request line is driven with a one-cycle glitch, a two-cycle pulse and a long hold, which separates the width filter from the synchronizer delay. Each handshake input is held off for several cycles and then released, so a transition that jumps early or stalls shows up. The acknowledge ready and the write-buffer indication are tried in both orders, and once with the buffer ignored, to separate the two-condition gate from either single condition. In stop-grant, the bus clock is toggled on its own and also dropped together with a request release, which exposes the exit priority. A withdrawal in mid-sequence exercises the sticky error while the sequence keeps running.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;

    localparam int unsigned NUM_STATES = 8;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_WAIT_BND = 3'd1,
        ST_FLUSH    = 3'd2,
        ST_DRAIN    = 3'd3,
        ST_ACK      = 3'd4,
        ST_WAIT_RDY = 3'd5,
        ST_GRANT    = 3'd6,
        ST_CLKOFF   = 3'd7
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       rdy_seen;
        logic       wbe_seen;
        logic       err;
    } seq_regs_t;

endpackage

// File: rtl/stopclk_sync.sv
module stopclk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/stopclk_qual.sv
module stopclk_qual #(
    parameter int unsigned MIN_PULSE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic valid_o
);
    localparam int unsigned CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] LIM = CW'(MIN_PULSE);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!level_i)          cnt_d = '0;
        else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign valid_o = (cnt_q == LIM);
endmodule

// File: rtl/stopclk_fsm.sv
module stopclk_fsm
    import stopclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_level,
    input  logic       req_valid,
    input  logic       insn_boundary,
    input  logic       flush_done,
    input  logic       bus_idle,
    input  logic       ack_ready,
    input  logic       wrbuf_empty,
    input  logic       wrbuf_ignore,
    input  logic       bus_clk_running,
    output seq_state_e state_o,
    output logic       err_o
);
    seq_regs_t d, q;
    logic      recog;
    logic      in_seq;
    logic      rdy_now;
    logic      wbe_now;

    always_comb begin
        d       = q;
        rdy_now = q.rdy_seen | ack_ready;
        wbe_now = q.wbe_seen | wrbuf_empty | wrbuf_ignore;
        recog   = (q.st == ST_WAIT_RDY) && rdy_now;
        in_seq  = (q.st != ST_RUN) && (q.st != ST_GRANT) && (q.st != ST_CLKOFF);

        // withdrawal before the acknowledge completes is a violation
        if (in_seq && !recog && !req_level) d.err = 1'b1;

        case (q.st)
            ST_RUN:      if (req_valid)     d.st = ST_WAIT_BND;
            ST_WAIT_BND: if (insn_boundary) d.st = ST_FLUSH;
            ST_FLUSH:    if (flush_done)    d.st = ST_DRAIN;
            ST_DRAIN:    if (bus_idle)      d.st = ST_ACK;
            ST_ACK:                         d.st = ST_WAIT_RDY;
            ST_WAIT_RDY: begin
                if (rdy_now && wbe_now) begin
                    d.st       = ST_GRANT;
                    d.rdy_seen = 1'b0;
                    d.wbe_seen = 1'b0;
                end else begin
                    d.rdy_seen = rdy_now;
                    d.wbe_seen = wbe_now;
                end
            end
            ST_GRANT: begin
                if (!req_level)            d.st = ST_RUN;
                else if (!bus_clk_running) d.st = ST_CLKOFF;
            end
            ST_CLKOFF:   if (bus_clk_running) d.st = ST_GRANT;
            default:                          d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_RUN, rdy_seen: 1'b0, wbe_seen: 1'b0, err: 1'b0};
        else        q <= d;
    end

    assign state_o = q.st;
    assign err_o   = q.err;
endmodule

// File: rtl/stopclk_seq.sv
module stopclk_seq
    import stopclk_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_PULSE   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stop_req_n,
    input  logic                  insn_boundary,
    output logic                  flush_req,
    input  logic                  flush_done,
    input  logic                  bus_idle,
    output logic                  ack_issue,
    input  logic                  ack_ready,
    input  logic                  wrbuf_empty,
    input  logic                  wrbuf_ignore,
    input  logic                  bus_clk_running,
    output logic                  core_clk_en,
    output logic [NUM_STATES-1:0] state_onehot,
    output logic                  proto_err
);
    logic       req_sync;
    logic       req_valid;
    seq_state_e cur_state;

    stopclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (~stop_req_n),
        .q_o   (req_sync)
    );

    stopclk_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (req_sync),
        .valid_o (req_valid)
    );

    stopclk_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_level       (req_sync),
        .req_valid       (req_valid),
        .insn_boundary   (insn_boundary),
        .flush_done      (flush_done),
        .bus_idle        (bus_idle),
        .ack_ready       (ack_ready),
        .wrbuf_empty     (wrbuf_empty),
        .wrbuf_ignore    (wrbuf_ignore),
        .bus_clk_running (bus_clk_running),
        .state_o         (cur_state),
        .err_o           (proto_err)
    );

    for (genvar g = 0; g < NUM_STATES; g++) begin : g_onehot
        assign state_onehot[g] = (cur_state == seq_state_e'(g));
    end

    assign flush_req   = (cur_state == ST_FLUSH);
    assign ack_issue   = (cur_state == ST_ACK);
    assign core_clk_en = !((cur_state == ST_GRANT) || (cur_state == ST_CLKOFF));
endmodule

// File: rtl/stopclk_seq_chk.sv
module stopclk_seq_chk
    import stopclk_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_idle,
    input logic                  flush_req,
    input logic                  ack_issue,
    input logic                  core_clk_en,
    input logic [NUM_STATES-1:0] state_onehot,
    input logic                  proto_err
);
    assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_onehot) == 1);

    assert_flush_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_req) |-> state_onehot[ST_DRAIN]);

    assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_issue |=> (!ack_issue && state_onehot[ST_WAIT_RDY]));

    assert_ack_after_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_issue) |-> $past(bus_idle));

    assert_gate_from_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_clk_en) |-> $past(state_onehot[ST_WAIT_RDY]));

    assert_clkoff_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_onehot[ST_CLKOFF]) |-> $past(state_onehot[ST_GRANT]));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
endmodule

bind stopclk_seq stopclk_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_idle     (bus_idle),
    .flush_req    (flush_req),
    .ack_issue    (ack_issue),
    .core_clk_en  (core_clk_en),
    .state_onehot (state_onehot),
    .proto_err    (proto_err)
);

// File: tb/stopclk_seq_tb.sv
module stopclk_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req_n = 1'b1;
    logic       insn_boundary = 1'b0;
    logic       flush_done = 1'b0;
    logic       bus_idle = 1'b0;
    logic       ack_ready = 1'b0;
    logic       wrbuf_empty = 1'b0;
    logic       wrbuf_ignore = 1'b0;
    logic       bus_clk_running = 1'b1;
    logic       flush_req, ack_issue, core_clk_en, proto_err;
    logic [7:0] state_onehot;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    localparam int RUN = 0, WBND = 1, FLSH = 2, DRN = 3, ACK = 4, WRDY = 5, GRNT = 6, COFF = 7;

    always #10 clk = ~clk;

    stopclk_seq u_dut (
        .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .insn_boundary(insn_boundary),
        .flush_req(flush_req), .flush_done(flush_done), .bus_idle(bus_idle),
        .ack_issue(ack_issue), .ack_ready(ack_ready), .wrbuf_empty(wrbuf_empty),
        .wrbuf_ignore(wrbuf_ignore), .bus_clk_running(bus_clk_running),
        .core_clk_en(core_clk_en), .state_onehot(state_onehot), .proto_err(proto_err)
    );

    // behavioural reference model
    int m_s1, m_s2, m_cnt, m_st, m_rdy, m_wbe, m_err;
    always @(posedge clk) begin
        int nst;
        int r;
        int w;
        bit recog;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_cnt = 0; m_st = RUN; m_rdy = 0; m_wbe = 0; m_err = 0;
        end else begin
            nst = m_st;
            recog = (m_st == WRDY) && (m_rdy != 0 || ack_ready);
            if (m_st >= WBND && m_st <= WRDY && m_s2 == 0 && !recog) m_err = 1;
            case (m_st)
                RUN:  if (m_cnt >= 2) nst = WBND;
                WBND: if (insn_boundary) nst = FLSH;
                FLSH: if (flush_done) nst = DRN;
                DRN:  if (bus_idle) nst = ACK;
                ACK:  nst = WRDY;
                WRDY: begin
                    r = (m_rdy != 0 || ack_ready) ? 1 : 0;
                    w = (m_wbe != 0 || wrbuf_empty || wrbuf_ignore) ? 1 : 0;
                    if (r != 0 && w != 0) begin nst = GRNT; m_rdy = 0; m_wbe = 0; end
                    else begin m_rdy = r; m_wbe = w; end
                end
                GRNT: if (m_s2 == 0) nst = RUN; else if (!bus_clk_running) nst = COFF;
                COFF: if (bus_clk_running) nst = GRNT;
                default: nst = RUN;
            endcase
            m_cnt = (m_s2 != 0) ? ((m_cnt < 2) ? m_cnt + 1 : 2) : 0;
            m_s2 = m_s1;
            m_s1 = stop_req_n ? 0 : 1;
            m_st = nst;
        end
    end

    task automatic cmp(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("R11 state_onehot", int'(state_onehot), 1 << m_st);
            cmp("R7 core_clk_en", int'(core_clk_en), (m_st == GRNT || m_st == COFF) ? 0 : 1);
            cmp("R4 flush_req", int'(flush_req), (m_st == FLSH) ? 1 : 0);
            cmp("R5 ack_issue", int'(ack_issue), (m_st == ACK) ? 1 : 0);
            cmp("R10 proto_err", int'(proto_err), m_err);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_state(input int idx, input int limit, input string tag);
        int k;
        k = 0;
        while (!state_onehot[idx] && k < limit) begin
            @(negedge clk);
            k++;
        end
        cmp(tag, int'(state_onehot), 1 << idx);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        cmp("R1 state", int'(state_onehot), 1);
        cmp("R1 clk_en", int'(core_clk_en), 1);
        cmp("R1 flush/ack/err", int'({flush_req, ack_issue, proto_err}), 0);

        // R2 single-cycle glitch is rejected
        stop_req_n = 1'b0; step(1); stop_req_n = 1'b1;
        step(8);
        cmp("R2 glitch ignored", int'(state_onehot), 1 << RUN);

        // main sequence, ready before write buffer
        stop_req_n = 1'b0;
        wait_state(WBND, 10, "R3 enter wait-boundary");
        step(5);
        cmp("R3 holds without boundary", int'(state_onehot), 1 << WBND);
        insn_boundary = 1'b1; step(1); insn_boundary = 1'b0;
        cmp("R3 boundary to flush", int'(state_onehot), 1 << FLSH);
        step(3);
        cmp("R4 flush_req held", int'(flush_req), 1);
        flush_done = 1'b1; step(1); flush_done = 1'b0;
        cmp("R4 flush to drain", int'(state_onehot), 1 << DRN);
        step(3);
        cmp("R5 drain waits idle", int'(state_onehot), 1 << DRN);
        bus_idle = 1'b1; step(1); bus_idle = 1'b0;
        cmp("R5 ack issued", int'(ack_issue), 1);
        step(1);
        cmp("R5 ack one cycle", int'({ack_issue, state_onehot[WRDY]}), 1);
        ack_ready = 1'b1; step(1); ack_ready = 1'b0;
        step(3);
        cmp("R6 waits write buffer", int'(state_onehot), 1 << WRDY);
        wrbuf_empty = 1'b1; step(1); wrbuf_empty = 1'b0;
        cmp("R6 grant", int'(state_onehot), 1 << GRNT);
        cmp("R7 clock gated", int'(core_clk_en), 0);
        bus_clk_running = 1'b0; step(1);
        cmp("R8 stop clock", int'(state_onehot), 1 << COFF);
        step(2);
        cmp("R8 stays stopped", int'(state_onehot), 1 << COFF);
        bus_clk_running = 1'b1; step(1);
        cmp("R8 back to grant", int'(state_onehot), 1 << GRNT);
        stop_req_n = 1'b1;
        wait_state(RUN, 6, "R9 exit to run");
        cmp("R9 clock restored", int'(core_clk_en), 1);
        cmp("R10 no violation", int'(proto_err), 0);

        // masked write buffer, exit priority
        step(3);
        wrbuf_ignore = 1'b1; insn_boundary = 1'b1; flush_done = 1'b1; bus_idle = 1'b1;
        stop_req_n = 1'b0;
        wait_state(WRDY, 20, "R6 reach wait-ready masked");
        insn_boundary = 1'b0; flush_done = 1'b0; bus_idle = 1'b0;
        step(2);
        cmp("R6 needs ready", int'(state_onehot), 1 << WRDY);
        ack_ready = 1'b1; step(1); ack_ready = 1'b0;
        cmp("R6 mask ignores buffer", int'(state_onehot), 1 << GRNT);
        stop_req_n = 1'b1; step(2);
        bus_clk_running = 1'b0; step(1);
        cmp("R9 release beats bus stop", int'(state_onehot), 1 << RUN);
        bus_clk_running = 1'b1; wrbuf_ignore = 1'b0;

        // protocol violation, buffer before ready
        step(3);
        stop_req_n = 1'b0;
        wait_state(WBND, 10, "R3 enter wait-boundary again");
        insn_boundary = 1'b1; step(1); insn_boundary = 1'b0;
        stop_req_n = 1'b1; step(4);
        cmp("R10 error flagged", int'(proto_err), 1);
        cmp("R10 sequence continues", int'(state_onehot), 1 << FLSH);
        flush_done = 1'b1; bus_idle = 1'b1;
        wait_state(WRDY, 10, "R5 reach wait-ready");
        flush_done = 1'b0; bus_idle = 1'b0;
        wrbuf_empty = 1'b1; step(1); wrbuf_empty = 1'b0;
        step(2);
        cmp("R6 buffer alone not enough", int'(state_onehot), 1 << WRDY);
        ack_ready = 1'b1; step(1); ack_ready = 1'b0;
        cmp("R6 grant after ready", int'(state_onehot), 1 << GRNT);
        wait_state(RUN, 4, "R9 released request returns");
        step(3);
        cmp("R10 error sticky", int'(proto_err), 1);

        // reset clears, two-cycle pulse qualifies
        do_reset();
        cmp("R1 error cleared", int'(proto_err), 0);
        stop_req_n = 1'b0; step(2); stop_req_n = 1'b1;
        wait_state(WBND, 8, "R2 two-cycle pulse accepted");
        insn_boundary = 1'b1; flush_done = 1'b1; bus_idle = 1'b1; ack_ready = 1'b1; wrbuf_empty = 1'b1;
        wait_state(RUN, 20, "R9 completes and returns");
        insn_boundary = 1'b0; flush_done = 1'b0; bus_idle = 1'b0; ack_ready = 1'b0; wrbuf_empty = 1'b0;
        step(2);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule